// File: doc/BRIEF.md
# Text Cursor Video Generator

This block decides, for every character clock, whether the cursor video signal is driven high. It watches the refresh memory address and the raster line that a display timing generator is scanning, and compares them against a programmed cursor position and a programmed band of raster lines. When the character under the beam is the cursor cell and the line falls inside the band, the cursor is shown, subject to a two-bit mode and to the display-enable window.

The mode selects a steady cursor, no cursor at all, or a cursor that blinks at one of two rates. Both rates are taken from a small frame counter that advances once per frame pulse. The frame pulse comes from the vertical sync logic. Register storage and the mixing of the cursor into the character video happen outside this block. The output is registered, so it lines up with a display enable that has passed through one stage of registers.

Top module: `txt_cursor_gen`

## Requirements
- R1: After reset the cursor output is low and the frame counter is zero, so a blinking cursor starts in its visible half.
- R2: The cursor is asserted only when the memory address equals the cursor position on all 14 bits.
- R3: The cursor is asserted only when first_raster <= raster <= last_raster. Both bounds are inclusive. If first_raster > last_raster, the cursor never shows.
- R4: While display enable is low the cursor output is low.
- R5: With mode 2'b00 the cursor is shown steadily, with no blinking, whenever R2, R3 and R4 allow it.
- R6: With mode 2'b01 the cursor is never shown.
- R7: With mode 2'b10 the cursor is shown while bit 3 of the frame counter is 0. It is therefore visible for 8 frames and hidden for 8 frames, a period of 16 frames.
- R8: With mode 2'b11 the cursor is shown while bit 4 of the frame counter is 0. It is visible for 16 frames and hidden for 16 frames, a period of 32 frames.
- R9: The frame counter is 5 bits wide and wraps from 31 to 0. It increments by one on each clock where frame_tick is high, and it is otherwise unchanged. The new count applies from the following clock onward.
- R10: The cursor output is registered. Its value after a clock edge depends only on the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | input | 14 | Refresh memory address being scanned |
| raster | input | 5 | Raster line within the character row |
| disp_en | input | 1 | Display-enable window |
| frame_tick | input | 1 | One-clock pulse per frame |
| cur_pos | input | 14 | Cursor position |
| first_raster | input | 5 | First raster line of the cursor band |
| last_raster | input | 5 | Last raster line of the cursor band |
| cur_mode | input | 2 | 00 steady, 01 hidden, 10 blink 16 frames, 11 blink 32 frames |
| cursor_out | output | 1 | Registered cursor video |

## Verification
Two functions of the block can fall in the same cycle:
- a frame pulse that moves the blink phase;
- an address and raster match that shows the cursor.

When both occur together, the output must follow the old phase, and the new phase must apply only on the next clock. The random stimulus pulses frame_tick on about one cycle in four while the address matches half the time. A directed sweep then holds a matching cell in each blink mode across more than 32 frames, with a pulse on every cycle. The bench keeps its own frame count. It judges every output against a phase computed before applying that cycle's pulse.

// File: rtl/txt_cursor_pkg.sv
package txt_cursor_pkg;

  typedef enum logic [1:0] {
    CUR_STEADY     = 2'b00,
    CUR_HIDDEN     = 2'b01,
    CUR_BLINK_FAST = 2'b10,
    CUR_BLINK_SLOW = 2'b11
  } cur_mode_e;

  // Visibility of the cursor for a mode, given the two blink phases
  // (a phase bit of 1 means "in the visible half").
  function automatic logic mode_visible(input cur_mode_e mode,
                                        input logic      fast_on,
                                        input logic      slow_on);
    logic v;
    case (mode)
      CUR_STEADY:     v = 1'b1;
      CUR_HIDDEN:     v = 1'b0;
      CUR_BLINK_FAST: v = fast_on;
      default:        v = slow_on;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/txt_cursor_blink.sv
module txt_cursor_blink #(
  parameter int CNT_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_tick,
  output logic fast_on,
  output logic slow_on
);
  localparam int FAST_BIT = CNT_W - 2;
  localparam int SLOW_BIT = CNT_W - 1;

  logic [CNT_W-1:0] frame_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          frame_cnt <= '0;
    else if (frame_tick) frame_cnt <= frame_cnt + CNT_W'(1);
  end

  assign fast_on = ~frame_cnt[FAST_BIT];
  assign slow_on = ~frame_cnt[SLOW_BIT];

  // R9: one step per frame pulse, wrapping naturally
  assert_frame_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> frame_cnt == $past(frame_cnt) + CNT_W'(1));
  assert_frame_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(frame_cnt));
  // R7/R8: the slow phase can only toggle when the fast phase wraps to visible
  assert_slow_follows_fast_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_on != $past(slow_on)) |-> (fast_on && !$past(fast_on)));

endmodule

// File: rtl/txt_cursor_match.sv
module txt_cursor_match #(
  parameter int ADDR_W = 14,
  parameter int RAS_W  = 5
) (
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [ADDR_W-1:0] cur_pos,
  input  logic [RAS_W-1:0]  raster,
  input  logic [RAS_W-1:0]  first_raster,
  input  logic [RAS_W-1:0]  last_raster,
  output logic              addr_hit,
  output logic              band_hit
);
  logic above_first, below_last;

  assign addr_hit    = (mem_addr == cur_pos);
  assign above_first = (raster >= first_raster);
  assign below_last  = (raster <= last_raster);
  assign band_hit    = above_first & below_last;

endmodule

// File: rtl/txt_cursor_gen.sv
module txt_cursor_gen
  import txt_cursor_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int RAS_W  = 5,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [RAS_W-1:0]  raster,
  input  logic              disp_en,
  input  logic              frame_tick,
  input  logic [ADDR_W-1:0] cur_pos,
  input  logic [RAS_W-1:0]  first_raster,
  input  logic [RAS_W-1:0]  last_raster,
  input  logic [1:0]        cur_mode,
  output logic              cursor_out
);
  logic      addr_hit, band_hit;
  logic      fast_on, slow_on;
  logic      visible;
  logic      cursor_d;
  cur_mode_e mode;

  assign mode = cur_mode_e'(cur_mode);

  txt_cursor_match #(.ADDR_W(ADDR_W), .RAS_W(RAS_W)) u_match (
    .mem_addr     (mem_addr),
    .cur_pos      (cur_pos),
    .raster       (raster),
    .first_raster (first_raster),
    .last_raster  (last_raster),
    .addr_hit     (addr_hit),
    .band_hit     (band_hit)
  );

  txt_cursor_blink #(.CNT_W(CNT_W)) u_blink (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .fast_on    (fast_on),
    .slow_on    (slow_on)
  );

  assign visible  = mode_visible(mode, fast_on, slow_on);
  assign cursor_d = disp_en & addr_hit & band_hit & visible;

  always_ff @(posedge clk) begin
    if (!rst_n) cursor_out <= 1'b0;
    else        cursor_out <= cursor_d;
  end

  // R4: blanking wins
  assert_blank_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |=> !cursor_out);
  // R2: wrong cell never shows
  assert_addr_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr != cur_pos) |=> !cursor_out);
  // R3: outside the raster band never shows
  assert_band_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((raster < first_raster) || (raster > last_raster)) |=> !cursor_out);
  // R6: hidden mode
  assert_hidden_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'b01) |=> !cursor_out);
  // R5: steady mode shows on every qualifying cycle
  assert_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'b00 && disp_en && mem_addr == cur_pos &&
     raster >= first_raster && raster <= last_raster) |=> cursor_out);

endmodule

// File: tb/txt_cursor_gen_tb.sv
module txt_cursor_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] mem_addr, cur_pos;
  logic [4:0]  raster, first_raster, last_raster;
  logic        disp_en, frame_tick;
  logic [1:0]  cur_mode;
  logic        cursor_out;

  int checks = 0;
  int failures = 0;
  int fc = 0;
  logic exp_prev = 1'b0;

  always #2 clk = ~clk;

  txt_cursor_gen u_dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .raster(raster),
    .disp_en(disp_en), .frame_tick(frame_tick), .cur_pos(cur_pos),
    .first_raster(first_raster), .last_raster(last_raster),
    .cur_mode(cur_mode), .cursor_out(cursor_out)
  );

  function automatic logic model_out(int cnt);
    logic vis;
    case (cur_mode)
      2'b00: vis = 1'b1;
      2'b01: vis = 1'b0;
      2'b10: vis = ((cnt >> 3) & 1) == 0;
      default: vis = ((cnt >> 4) & 1) == 0;
    endcase
    return disp_en && (mem_addr == cur_pos) && (first_raster <= raster) &&
           (raster <= last_raster) && vis;
  endfunction

  function automatic string model_tag();
    if (!disp_en) return "R4";
    if (mem_addr != cur_pos) return "R2";
    if (!(first_raster <= raster && raster <= last_raster)) return "R3";
    case (cur_mode)
      2'b00: return "R5";
      2'b01: return "R6";
      2'b10: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b time=%0t", req, act, exp, $time);
    end
  endtask

  // Called just after a negedge with inputs already driven.
  task automatic run_cycle(input string force_tag = "");
    logic  exp_next;
    string tag;
    exp_next = model_out(fc);
    tag = (force_tag != "") ? force_tag : model_tag();
    #1 check("R10", cursor_out, exp_prev);
    @(posedge clk);
    if (frame_tick) fc = (fc + 1) % 32;   // R9 model
    #1 check(tag, cursor_out, exp_next);
    exp_prev = exp_next;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; mem_addr = '0; cur_pos = '0; raster = '0;
    first_raster = '0; last_raster = '0; disp_en = 1'b0;
    frame_tick = 1'b0; cur_mode = 2'b00;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", cursor_out, 1'b0);
    rst_n = 1'b1;

    // R1: counter starts at zero, slow blink visible at once
    cur_pos = 14'h1ABC; mem_addr = 14'h1ABC; raster = 5'd3;
    first_raster = 5'd2; last_raster = 5'd5; disp_en = 1'b1; cur_mode = 2'b11;
    run_cycle("R1");

    // R2: a single flipped address bit (top and bottom)
    mem_addr = 14'h3ABC; run_cycle("R2");
    mem_addr = 14'h1ABD; run_cycle("R2");
    mem_addr = 14'h1ABC;

    // R3: band edges, inclusive, and inverted band
    cur_mode = 2'b00;
    raster = 5'd2; run_cycle("R3");
    raster = 5'd5; run_cycle("R3");
    raster = 5'd1; run_cycle("R3");
    raster = 5'd6; run_cycle("R3");
    first_raster = 5'd7; last_raster = 5'd4; raster = 5'd5; run_cycle("R3");
    first_raster = 5'd9; last_raster = 5'd9; raster = 5'd9; run_cycle("R3");

    // R4: blanking overrides a full match
    disp_en = 1'b0; run_cycle("R4");
    disp_en = 1'b1;

    // R6: hidden mode with a full match
    cur_mode = 2'b01; run_cycle("R6");

    // R7 / R8 / R9: frame pulse on every cycle through more than two full periods
    cur_mode = 2'b10;
    frame_tick = 1'b1;
    for (int i = 0; i < 40; i++) run_cycle("R7");
    cur_mode = 2'b11;
    for (int i = 0; i < 70; i++) run_cycle("R8");
    frame_tick = 1'b0;
    for (int i = 0; i < 4; i++) run_cycle("R9");

    // Random mix
    for (int i = 0; i < 6000; i++) begin
      cur_mode     = 2'($urandom_range(0, 3));
      cur_pos      = 14'($urandom);
      mem_addr     = ($urandom_range(0, 1) == 0) ? cur_pos : 14'($urandom);
      first_raster = 5'($urandom_range(0, 12));
      last_raster  = 5'($urandom_range(0, 15));
      raster       = 5'($urandom_range(0, 15));
      disp_en      = ($urandom_range(0, 9) != 0);
      frame_tick   = ($urandom_range(0, 3) == 0);
      run_cycle();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule